// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block turns a byte-wide host command stream into accesses to a 256-location, 8-bit register space that sits outside the block. Each command byte has a 4-bit opcode in its upper half and a 4-bit operand in its lower half. Because one command carries only one nibble, a full register address or data byte takes two commands.

The host first builds the address from two nibbles. It then latches the low data nibble. A final command supplies the high data nibble and commits the write. Read commands fetch the register at the current address and return the byte on a response channel with a valid/ready handshake. Both write-commit and read commands can step the address up or down after the access, so a burst over neighbouring registers needs no address reload.

The register space is not part of this block. The block drives a write strobe and a read request. The register file answers the read combinationally on `rd_data` in the same cycle, and that file may map reads and writes at one address to different registers.

Top module: `nibcmd_regport`

## Requirements
- R1: A command is accepted on a cycle where `cmd_valid` and `cmd_ready` are both high. Its opcode is bits 7:4 and its operand is bits 3:0. Opcode 0x0 loads the operand into address bits 3:0, and opcode 0x1 loads it into address bits 7:4.
- R2: Opcode 0x2 latches the operand as the low data nibble. Opcode 0x3 raises `wr_en` for exactly the one cycle after acceptance, with `wr_addr` set to the address in effect when the command was accepted and `wr_data` set to {operand, latched nibble}. `wr_en` is never high otherwise.
- R3: Opcode 0x4 raises `rd_req` combinationally in the accepting cycle, with `rd_addr` set to the current address. In the next cycle `rsp_valid` is high and `rsp_data` holds the `rd_data` value seen in the accepting cycle.
- R4: After an opcode 0x3 or 0x4 command whose operand bit 0 is 1, the address steps by one. It decrements when operand bit 1 is 1 and increments when operand bit 1 is 0. With operand bit 0 at 0 the address is unchanged.
- R5: Address stepping wraps modulo 256: incrementing from 0xFF gives 0x00, and decrementing from 0x00 gives 0xFF.
- R6: Opcodes 0x5 through 0xF produce no write strobe and no read request. They change neither the address nor the latched data nibble.
- R7: While `rsp_valid` is high, `cmd_ready` is low. `rsp_valid` and `rsp_data` hold until `rsp_ready` is seen high, and `rsp_valid` then falls in the next cycle.
- R8: After reset the address is 0x00 and the latched nibble is 0x0. `wr_en` and `rsp_valid` are low, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_data | input | 8 | Command byte: opcode 7:4, operand 3:0 |
| cmd_ready | output | 1 | Block can accept a command |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 8 | Register write data |
| rd_req | output | 1 | Register read request, combinational |
| rd_addr | output | 8 | Register read address |
| rd_data | input | 8 | Read data returned by the register file in the same cycle |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_ready | input | 1 | Downstream accepts the response |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the intake stall while a response is pending, and response stability under back-pressure;
- a strobe or response following only the matching opcode;
- address stepping by plus or minus one;
- ignored opcodes leaving the address and the nibble untouched.

Other behaviours only the bench scenarios can show, because they need a model of the register contents and of the assembled address:
- the exact address and data values that reach the register file, built from nibbles across several commands;
- the wrap at 0x00 and 0xFF in both directions;
- read data matching what earlier writes stored.

// File: rtl/nibcmd_regport.sv
module nibcmd_regport (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_data,
  output logic       cmd_ready,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_req,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  input  logic       rsp_ready
);
  localparam logic [3:0] OP_ALO = 4'h0;
  localparam logic [3:0] OP_AHI = 4'h1;
  localparam logic [3:0] OP_DLO = 4'h2;
  localparam logic [3:0] OP_WR  = 4'h3;
  localparam logic [3:0] OP_RD  = 4'h4;

  logic [7:0] addr;
  logic [3:0] dlo;

  wire       acc  = cmd_valid && cmd_ready;
  wire [3:0] op   = cmd_data[7:4];
  wire [3:0] arg  = cmd_data[3:0];
  wire       step = acc && (op == OP_WR || op == OP_RD) && arg[0];
  wire [7:0] addr_adj = arg[1] ? addr - 8'd1 : addr + 8'd1;

  assign cmd_ready = !rsp_valid;
  assign rd_req    = acc && (op == OP_RD);
  assign rd_addr   = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      dlo       <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (acc) begin
        case (op)
          OP_ALO: addr[3:0] <= arg;
          OP_AHI: addr[7:4] <= arg;
          OP_DLO: dlo <= arg;
          OP_WR: begin
            wr_en   <= 1'b1;
            wr_addr <= addr;
            wr_data <= {arg, dlo};
          end
          default: ;
        endcase
      end
      if (step) addr <= addr_adj;
      if (rd_req) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nibcmd_regport_chk.sv
module nibcmd_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_data,
  input logic       cmd_ready,
  input logic       wr_en,
  input logic       rd_req,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic       rsp_ready,
  input logic [7:0] addr,
  input logic [3:0] dlo
);
  wire acc = cmd_valid && cmd_ready;

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_rd_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  assert_wr_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(acc && cmd_data[7:4] == 4'h3));

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_data[7:4] == 4'h3 || cmd_data[7:4] == 4'h4) && cmd_data[1:0] == 2'b01)
      |=> addr == $past(addr) + 8'd1);

  assert_step_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_data[7:4] == 4'h3 || cmd_data[7:4] == 4'h4) && cmd_data[1:0] == 2'b11)
      |=> addr == $past(addr) - 8'd1);

  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_data[7:4] >= 4'h5) |=> ($stable(addr) && $stable(dlo) && !wr_en));
endmodule

bind nibcmd_regport nibcmd_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
  .cmd_ready(cmd_ready), .wr_en(wr_en), .rd_req(rd_req), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .rsp_ready(rsp_ready), .addr(addr), .dlo(dlo)
);

// File: tb/nibcmd_regport_bench.sv
`timescale 1ns/1ps
module nibcmd_regport_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_data = '0;
  logic rsp_ready = 1'b0;
  logic cmd_ready, wr_en, rd_req, rsp_valid;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data, rsp_data;

  int tests = 0;
  int fails = 0;
  logic [7:0] regf [256];
  logic [7:0] shadow [256];
  logic [7:0] exp_addr = 8'h00;
  logic [3:0] exp_dlo = 4'h0;

  always #4 clk = ~clk;

  nibcmd_regport u_nibcmd_regport (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready)
  );

  assign rd_data = regf[rd_addr];
  always @(posedge clk) if (wr_en) regf[wr_addr] <= wr_data;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stepped(input logic [7:0] a, input logic [3:0] arg);
    if (!arg[0]) return a;
    return arg[1] ? a - 8'd1 : a + 8'd1;
  endfunction

  task automatic send(input logic [7:0] c, input int stall);
    logic [3:0] op, arg;
    logic [7:0] rexp;
    op = c[7:4];
    arg = c[3:0];
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data = c;
    #1;
    if (op == 4'h4) begin
      chk(rd_req === 1'b1, "R3 rd_req", int'(rd_req), 1);
      chk(rd_addr === exp_addr, "R3 rd_addr", int'(rd_addr), int'(exp_addr));
    end else begin
      chk(rd_req === 1'b0, "R6 no rd_req", int'(rd_req), 0);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 4'h3) begin
      chk(wr_en === 1'b1, "R2 wr_en", int'(wr_en), 1);
      chk(wr_addr === exp_addr, "R2 wr_addr", int'(wr_addr), int'(exp_addr));
      chk(wr_data === {arg, exp_dlo}, "R2 wr_data", int'(wr_data), int'({arg, exp_dlo}));
      shadow[exp_addr] = {arg, exp_dlo};
      exp_addr = stepped(exp_addr, arg);
    end else begin
      chk(wr_en === 1'b0, "R6 no wr_en", int'(wr_en), 0);
      case (op)
        4'h0: exp_addr[3:0] = arg;
        4'h1: exp_addr[7:4] = arg;
        4'h2: exp_dlo = arg;
        4'h4: begin
          rexp = shadow[exp_addr];
          chk(rsp_valid === 1'b1, "R3 rsp_valid", int'(rsp_valid), 1);
          chk(rsp_data === rexp, "R3 rsp_data", int'(rsp_data), int'(rexp));
          chk(cmd_ready === 1'b0, "R7 stall", int'(cmd_ready), 0);
          for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk(rsp_valid === 1'b1 && rsp_data === rexp, "R7 hold",
                int'(rsp_data), int'(rexp));
            chk(cmd_ready === 1'b0, "R7 stall", int'(cmd_ready), 0);
          end
          rsp_ready = 1'b1;
          @(negedge clk);
          rsp_ready = 1'b0;
          chk(rsp_valid === 1'b0, "R7 release", int'(rsp_valid), 0);
          chk(cmd_ready === 1'b1, "R7 ready", int'(cmd_ready), 1);
          exp_addr = stepped(exp_addr, arg);
        end
        default: ;
      endcase
    end
  endtask

  task automatic set_addr(input logic [7:0] a);
    send({4'h0, a[3:0]}, 0);
    send({4'h1, a[7:4]}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < 256; i++) begin
      regf[i] = 8'((i * 37 + 5) & 8'hFF);
      shadow[i] = 8'((i * 37 + 5) & 8'hFF);
    end
    repeat (3) @(negedge clk);
    chk(wr_en === 1'b0 && rsp_valid === 1'b0, "R8 outputs idle", int'({wr_en, rsp_valid}), 0);
    chk(cmd_ready === 1'b1, "R8 ready", int'(cmd_ready), 1);
    rst_n = 1'b1;
    // R8: first write with no address or nibble load goes to 0x00 with low nibble 0
    send(8'h3A, 0);
    // R1 R2 directed write and read back
    set_addr(8'hC5);
    send(8'h27, 0);
    send(8'h39, 0);
    send(8'h40, 2);
    // R5 wrap up from 0xFF and down from 0x00
    set_addr(8'hFF);
    send(8'h21, 0);
    send(8'h31, 0);
    send(8'h32, 0);
    send(8'h43, 1);
    send(8'h40, 0);
    // R4 bit0 clear with bit1 set: no step
    set_addr(8'h40);
    send(8'h32, 0);
    send(8'h40, 0);
    // R6 ignored opcodes leave address and nibble untouched
    set_addr(8'h17);
    send(8'h2B, 0);
    for (int o = 5; o < 16; o++) send({4'(o), 4'hF}, 0);
    send(8'h30, 0);
    send(8'h40, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [3:0] op;
      r = int'($urandom % 8);
      op = (r < 5) ? 4'(r) : 4'(5 + $urandom % 11);
      send({op, 4'($urandom % 16)}, int'($urandom % 4));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule